// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of an event timer. The main counter is shared and lives outside the channel. Each step of that counter is compared against a 32-bit comparator. When the two match, the channel either fires once (one-shot) or reloads itself by a programmed period (periodic). A fire can be delivered in three ways: as a level held on a routed interrupt line, as a one-cycle edge pulse on that line, or as a message request that carries a 32-bit address and a 32-bit data word.

The channel holds four pieces of state: a 64-bit configuration word whose upper half is a read-only mask of the lines it may use, the comparator, the period, and a 64-bit message register. It also owns its own bit of the interrupt status. Software reaches these through plain write strobes from an outside decoder. A route value that the mask does not allow is replaced by zero, and zero means the channel is not connected to any line. Some configuration changes clear a pending level status, so that the line cannot stay stuck high.

Top module: `tmr_chan`

## Requirements
- R1: After reset the comparator reads 0xFFFFFFFF and the period reads 0. The configuration reads {allowed mask 0xFF000000, 16'h0000, 16'h8010}: bit 15 is message capability, set, and bit 4 is periodic capability, set. The status, the line and the message request are all low.
- R2: A configuration write changes only the writable bits, and only in the 32-bit halves whose strobe is set (wstrb_i[0] for bits 31:0, wstrb_i[1] for bits 63:32). The writable bits are: bit 1 (level type), bit 2 (interrupt enable), bit 3 (periodic), bit 6 (value-set), bits 13:9 (route) and bit 14 (message enable). Every other bit keeps its value, including bit 8 (32-bit mode), which stays 0.
- R3: When a write leaves a nonzero route whose bit is clear in the allowed mask (bits 63:32), the route field is stored as 0.
- R4: The channel fires only when all of these hold: count_step_i is high, glb_en_i is high, the channel is active (interrupt enable or periodic set), and count_i equals the comparator.
- R5: In periodic mode a comparator write (wdata_i[31:0]) always loads the period. It also loads the comparator, but only when value-set is 1. Value-set reads 0 after any comparator write.
- R6: In one-shot mode a comparator write loads the comparator and sets the period to 0. A configuration write that clears the periodic bit also sets the period to 0.
- R7: A periodic fire adds the period to the comparator, so the new value shows one cycle after the matching step. A one-shot fire leaves the comparator unchanged.
- R8: With interrupt enable clear, a fire raises no line and no message request.
- R9: When both bit 15 and bit 14 are set, a fire pulses msg_req_o for one cycle, starting the cycle after the match. During that pulse msg_addr_o shows message bits 63:32 and msg_data_o shows bits 31:0, and the line stays low.
- R10: In edge type (bit 1 clear) with a nonzero route, a fire pulses irq_line_o for exactly one cycle. With route 0, nothing is raised.
- R11: In level type with a nonzero route, a fire sets the status bit and holds the line high. A further fire while the bit is set changes nothing. A sts_clr_i pulse clears the bit and drops the line.
- R12: A configuration write clears a set status bit if it disables the interrupt, changes the type to edge or message, or changes the route. A write that changes none of these leaves the status bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_i | input | 32 | Current main counter value |
| count_step_i | input | 1 | Counter took a new value this cycle |
| glb_en_i | input | 1 | Global timer enable |
| cfg_we_i | input | 1 | Configuration write strobe |
| cmp_we_i | input | 1 | Comparator write strobe |
| msg_we_i | input | 1 | Message register write strobe |
| wstrb_i | input | 2 | 32-bit half select for 64-bit writes |
| wdata_i | input | 64 | Write data |
| sts_clr_i | input | 1 | Clear the channel status bit |
| cfg_o | output | 64 | Configuration register |
| cmp_o | output | 32 | Comparator |
| period_o | output | 32 | Period |
| msg_o | output | 64 | Message register |
| sts_o | output | 1 | Channel status bit |
| irq_line_o | output | 1 | Interrupt line (level or pulse) |
| irq_route_o | output | 5 | Line number the interrupt is routed to |
| msg_req_o | output | 1 | One-cycle message request |
| msg_addr_o | output | 32 | Message address |
| msg_data_o | output | 32 | Message data |

## Verification
Some rules are checked by assertions on every cycle:
- the stored route is always legal;
- the read-only fields never change;
- a one-shot channel always has a zero period;
- a periodic fire advances the comparator;
- value-set clears itself;
- a level status holds until cleared;
- message requests and edge pulses never occur together.

Other behaviour can only be shown by the bench's scenarios:
- whether a comparator write lands in the period or the comparator;
- the exact address and data carried by a message;
- which configuration changes drop a pending status and which leave it set;
- that a disabled global enable or a missing route suppresses a fire.

// File: rtl/tmr_chan_pkg.sv
// Package: bit positions and the decoded-field type for the timer channel.
package tmr_chan_pkg;
    localparam int B_LVL  = 1;
    localparam int B_IEN  = 2;
    localparam int B_PER  = 3;
    localparam int B_PCAP = 4;
    localparam int B_SIZE = 5;
    localparam int B_VSET = 6;
    localparam int B_M32  = 8;
    localparam int B_RTLO = 9;
    localparam int RTW    = 5;
    localparam int B_MEN  = 14;
    localparam int B_MCAP = 15;
    localparam logic [63:0] WR_MASK = 64'h0000_0000_0000_7E4E;

    typedef struct packed {
        logic           lvl;
        logic           ien;
        logic           per;
        logic           vset;
        logic           msg;
        logic [RTW-1:0] route;
    } cfg_f_t;

    function automatic cfg_f_t decode(input logic [63:0] c);
        cfg_f_t f;
        f.lvl   = c[B_LVL];
        f.ien   = c[B_IEN];
        f.per   = c[B_PER];
        f.vset  = c[B_VSET];
        f.msg   = c[B_MEN] & c[B_MCAP];
        f.route = c[B_RTLO +: RTW];
        return f;
    endfunction
endpackage

// File: rtl/tmr_chan_cfg.sv
// Configuration register of one channel.
// Merges writable fields per 32-bit strobe and keeps read-only capability
// bits. Replaces an unallowed route with 0 and self-clears value-set on
// comparator writes. Assumes cfg and comparator writes never share a cycle.
module tmr_chan_cfg
    import tmr_chan_pkg::*;
#(
    parameter logic [31:0] ALLOWED = 32'hFF00_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic        cmp_we,
    input  logic [1:0]  wstrb,
    input  logic [63:0] wdata,
    output logic [63:0] cfg_q,
    output cfg_f_t      cur_f,
    output cfg_f_t      nxt_f
);
    localparam logic [63:0] RST_CFG = {ALLOWED, 16'h0000, 16'h8010};

    logic [63:0] lane_m;
    logic [63:0] merged;

    // Build the candidate value of a write, with route validation.
    always_comb begin
        lane_m = {{32{wstrb[1]}}, {32{wstrb[0]}}} & WR_MASK;
        merged = (cfg_q & ~lane_m) | (wdata & lane_m);
        if (merged[B_RTLO +: RTW] != '0 && !ALLOWED[merged[B_RTLO +: RTW]])
            merged[B_RTLO +: RTW] = '0;
    end

    assign cur_f = decode(cfg_q);
    assign nxt_f = decode(merged);

    // Register update: write, value-set self-clear, reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= RST_CFG;
        else if (cfg_we) cfg_q <= merged;
        else if (cmp_we) cfg_q[B_VSET] <= 1'b0;
    end

    AST_ROUTE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[B_RTLO +: RTW] == '0 || ALLOWED[cfg_q[B_RTLO +: RTW]]); // R3
    AST_RO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[63:32] == ALLOWED && cfg_q[B_PCAP] && cfg_q[B_MCAP]
        && !cfg_q[B_M32] && !cfg_q[B_SIZE]); // R2
    AST_VSET_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we && !cfg_we |=> !cfg_q[B_VSET]); // R5
endmodule

// File: rtl/tmr_chan_cmp.sv
// Comparator and period of one channel.
// Applies the periodic and one-shot write rules, detects a match on a counter
// step, and reloads the comparator on a periodic fire. Assumes at most one
// counter step per cycle.
module tmr_chan_cmp
    import tmr_chan_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cfg_f_t        cur_f,
    input  cfg_f_t        nxt_f,
    input  logic          cfg_we,
    input  logic          cmp_we,
    input  logic [CW-1:0] wval,
    input  logic [CW-1:0] count,
    input  logic          step,
    input  logic          glb_en,
    output logic [CW-1:0] cmp_q,
    output logic [CW-1:0] period_q,
    output logic          fire
);
    logic active;

    // Match detection, at most once per counter step.
    always_comb begin
        active = cur_f.ien | cur_f.per;
        fire   = step & glb_en & active & (count == cmp_q);
    end

    // Comparator update: writes, periodic reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '1;
        end else if (cmp_we) begin
            if (!cur_f.per || cur_f.vset) cmp_q <= wval;
        end else if (fire && cur_f.per) begin
            cmp_q <= cmp_q + period_q;
        end
    end

    // Period update: periodic writes load it, one-shot forces zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                     period_q <= '0;
        else if (cmp_we)                period_q <= cur_f.per ? wval : '0;
        else if (cfg_we && !nxt_f.per)  period_q <= '0;
    end

    AST_ONESHOT_ZERO_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_f.per |-> period_q == '0); // R6
    AST_PER_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        fire && cur_f.per && !cmp_we |=> cmp_q == $past(cmp_q) + $past(period_q)); // R7
    AST_NO_FIRE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en || !step |-> !fire); // R4
endmodule

// File: rtl/tmr_chan_irq.sv
// Interrupt delivery of one channel.
// Chooses message, edge or level from the configuration, holds the level
// status until it is cleared, and drops it on relevant reconfiguration.
// Assumes a status clear and a fire never share a cycle.
module tmr_chan_irq
    import tmr_chan_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  cfg_f_t      cur_f,
    input  cfg_f_t      nxt_f,
    input  logic        cfg_we,
    input  logic        fire,
    input  logic        sts_clr,
    input  logic [63:0] msg_reg,
    output logic        sts_q,
    output logic        irq_line,
    output logic        msg_req,
    output logic [31:0] msg_addr,
    output logic [31:0] msg_data
);
    logic fire_irq;
    logic routed;
    logic chg_clr;
    logic pulse_q;

    // Classify the fire and work out the reconfiguration clear.
    always_comb begin
        fire_irq = fire & cur_f.ien;
        routed   = cur_f.route != '0;
        chg_clr  = cfg_we && sts_q &&
                   (!routed || !nxt_f.ien || nxt_f.msg || !nxt_f.lvl
                    || nxt_f.route != cur_f.route);
    end

    // Message request and edge pulse, one cycle each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_req  <= 1'b0;
            pulse_q  <= 1'b0;
            msg_addr <= '0;
            msg_data <= '0;
        end else begin
            msg_req <= fire_irq & cur_f.msg;
            pulse_q <= fire_irq & !cur_f.msg & !cur_f.lvl & routed;
            if (fire_irq && cur_f.msg) begin
                msg_addr <= msg_reg[63:32];
                msg_data <= msg_reg[31:0];
            end
        end
    end

    // Level status: set on fire, held while set, cleared by software or reconfig.
    always_ff @(posedge clk) begin
        if (!rst_n)                 sts_q <= 1'b0;
        else if (chg_clr || sts_clr) sts_q <= 1'b0;
        else if (fire_irq && !cur_f.msg && cur_f.lvl && routed) sts_q <= 1'b1;
    end

    assign irq_line = sts_q | pulse_q;

    AST_MSG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(msg_req && irq_line)); // R9
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sts_q && !sts_clr && !cfg_we |=> sts_q); // R11
    AST_STS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sts_clr && !fire |=> !sts_q); // R11
    AST_IEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !cur_f.ien |=> !msg_req && !pulse_q); // R8
endmodule

// File: rtl/tmr_chan.sv
// Top of one event-timer comparator channel.
// Ties together configuration, comparator and interrupt delivery, and holds
// the message register. The main counter and bus decoding live outside.
module tmr_chan
    import tmr_chan_pkg::*;
#(
    parameter int          CW      = 32,
    parameter logic [31:0] ALLOWED = 32'hFF00_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count_i,
    input  logic          count_step_i,
    input  logic          glb_en_i,
    input  logic          cfg_we_i,
    input  logic          cmp_we_i,
    input  logic          msg_we_i,
    input  logic [1:0]    wstrb_i,
    input  logic [63:0]   wdata_i,
    input  logic          sts_clr_i,
    output logic [63:0]   cfg_o,
    output logic [CW-1:0] cmp_o,
    output logic [CW-1:0] period_o,
    output logic [63:0]   msg_o,
    output logic          sts_o,
    output logic          irq_line_o,
    output logic [RTW-1:0] irq_route_o,
    output logic          msg_req_o,
    output logic [31:0]   msg_addr_o,
    output logic [31:0]   msg_data_o
);
    cfg_f_t cur_f;
    cfg_f_t nxt_f;
    logic   fire;

    tmr_chan_cfg #(.ALLOWED(ALLOWED)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we_i), .cmp_we(cmp_we_i),
        .wstrb(wstrb_i), .wdata(wdata_i), .cfg_q(cfg_o),
        .cur_f(cur_f), .nxt_f(nxt_f)
    );

    tmr_chan_cmp #(.CW(CW)) u_cmp (
        .clk(clk), .rst_n(rst_n), .cur_f(cur_f), .nxt_f(nxt_f),
        .cfg_we(cfg_we_i), .cmp_we(cmp_we_i), .wval(wdata_i[CW-1:0]),
        .count(count_i), .step(count_step_i), .glb_en(glb_en_i),
        .cmp_q(cmp_o), .period_q(period_o), .fire(fire)
    );

    tmr_chan_irq u_irq (
        .clk(clk), .rst_n(rst_n), .cur_f(cur_f), .nxt_f(nxt_f),
        .cfg_we(cfg_we_i), .fire(fire), .sts_clr(sts_clr_i), .msg_reg(msg_o),
        .sts_q(sts_o), .irq_line(irq_line_o), .msg_req(msg_req_o),
        .msg_addr(msg_addr_o), .msg_data(msg_data_o)
    );

    // Message register, written per 32-bit half.
    always_ff @(posedge clk) begin
        if (!rst_n) msg_o <= '0;
        else if (msg_we_i) begin
            if (wstrb_i[0]) msg_o[31:0]  <= wdata_i[31:0];
            if (wstrb_i[1]) msg_o[63:32] <= wdata_i[63:32];
        end
    end

    assign irq_route_o = cur_f.route;
endmodule

// File: tb/tb_tmr_chan.sv
`timescale 1ns/1ps
module tb_tmr_chan;
    localparam logic [31:0] ALW = 32'hFF00_0000;
    localparam logic [63:0] RST_CFG = {ALW, 32'h0000_8010};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] count_i = '0;
    logic        count_step_i = 1'b0, glb_en_i = 1'b0;
    logic        cfg_we_i = 1'b0, cmp_we_i = 1'b0, msg_we_i = 1'b0, sts_clr_i = 1'b0;
    logic [1:0]  wstrb_i = '0;
    logic [63:0] wdata_i = '0;
    logic [63:0] cfg_o, msg_o;
    logic [31:0] cmp_o, period_o, msg_addr_o, msg_data_o;
    logic        sts_o, irq_line_o, msg_req_o;
    logic [4:0]  irq_route_o;

    int checks = 0, errors = 0;
    logic [63:0] cfg_m;
    bit done = 0;

    tmr_chan dut (.*);

    always #2 clk = ~clk;

    function automatic logic [63:0] exp_cfg(logic [63:0] old, logic [63:0] d, logic [1:0] s);
        logic [63:0] m, n;
        m = {{32{s[1]}}, {32{s[0]}}} & 64'h7E4E;
        n = (old & ~m) | (d & m);
        if (n[13:9] != 0 && !ALW[n[13:9]]) n[13:9] = '0;
        return n;
    endfunction

    function automatic logic [63:0] cw(bit lvl, bit ien, bit per, bit vset, bit men, logic [4:0] rt);
        return 64'(lvl) << 1 | 64'(ien) << 2 | 64'(per) << 3 | 64'(vset) << 6
             | 64'(rt) << 9 | 64'(men) << 14;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cfg_m = RST_CFG;
    endtask

    task automatic cfg_wr(logic [63:0] d, logic [1:0] s);
        cfg_we_i = 1; wdata_i = d; wstrb_i = s;
        @(negedge clk);
        cfg_we_i = 0;
        cfg_m = exp_cfg(cfg_m, d, s);
    endtask

    task automatic cmp_wr(logic [31:0] v);
        cmp_we_i = 1; wdata_i = {32'h0, v}; wstrb_i = 2'b01;
        @(negedge clk);
        cmp_we_i = 0;
    endtask

    task automatic msg_wr(logic [63:0] v);
        msg_we_i = 1; wdata_i = v; wstrb_i = 2'b11;
        @(negedge clk);
        msg_we_i = 0;
    endtask

    task automatic tick(logic [31:0] v);
        count_i = v; count_step_i = 1;
        @(negedge clk);
        count_step_i = 0;
    endtask

    task automatic clr();
        sts_clr_i = 1;
        @(negedge clk);
        sts_clr_i = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1 cfg", cfg_o, RST_CFG);
        check("R1 cmp", cmp_o, 32'hFFFF_FFFF);
        check("R1 period", period_o, 0);
        check("R1 outputs", {sts_o, irq_line_o, msg_req_o}, 0);

        // R2 R3 random configuration writes against model
        for (int i = 0; i < 60; i++) begin
            logic [63:0] d;
            d = {$urandom, $urandom};
            cfg_wr(d, 2'($urandom));
            check("R2 random cfg", cfg_o, cfg_m);
        end
        do_reset();
        cfg_wr(cw(0, 0, 0, 0, 0, 5'd5), 2'b01);
        check("R3 illegal route", irq_route_o, 0);
        cfg_wr(cw(0, 0, 0, 0, 0, 5'd24), 2'b01);
        check("R3 legal route", irq_route_o, 24);
        cfg_wr(64'hFFFF_FFFF_FFFF_FFFF, 2'b10);
        check("R2 upper half read-only", cfg_o, cfg_m);
        check("R2 model upper", cfg_o[63:32], ALW);

        // R5 periodic writes with value-set
        cfg_wr(cw(0, 1, 1, 1, 0, 5'd24), 2'b01);
        cmp_wr(100);
        check("R5 cmp loaded", cmp_o, 100);
        check("R5 period loaded", period_o, 100);
        check("R5 vset cleared", cfg_o[6], 0);
        cmp_wr(50);
        check("R5 cmp kept", cmp_o, 100);
        check("R5 period only", period_o, 50);

        // R4 R7 R10 periodic edge fire
        glb_en_i = 1;
        tick(99);
        check("R4 no match", irq_line_o, 0);
        tick(100);
        check("R10 edge pulse", irq_line_o, 1);
        check("R7 periodic advance", cmp_o, 150);
        @(negedge clk);
        check("R10 pulse one cycle", irq_line_o, 0);
        glb_en_i = 0;
        tick(150);
        check("R4 global disabled", {cmp_o, 31'h0, irq_line_o}, {32'd150, 32'h0});
        glb_en_i = 1;

        // R6 R7 one-shot
        cfg_wr(cw(0, 1, 0, 0, 0, 5'd24), 2'b01);
        check("R6 period zeroed", period_o, 0);
        cmp_wr(200);
        check("R6 one-shot cmp", {cmp_o, period_o}, {32'd200, 32'd0});
        tick(200);
        check("R7 one-shot fire", irq_line_o, 1);
        check("R7 one-shot cmp kept", cmp_o, 200);

        // R4 R8 inactive and enable-clear
        cfg_wr(cw(0, 0, 0, 0, 0, 5'd24), 2'b01);
        tick(200);
        check("R4 inactive", irq_line_o, 0);
        cfg_wr(cw(0, 0, 1, 1, 0, 5'd24), 2'b01);
        cmp_wr(10);
        tick(10);
        check("R8 no line", {irq_line_o, msg_req_o}, 0);
        check("R8 still advances", cmp_o, 20);

        // R11 R12 level
        cfg_wr(cw(1, 1, 0, 0, 0, 5'd25), 2'b01);
        cmp_wr(300);
        tick(300);
        check("R11 level set", {sts_o, irq_line_o}, 2'b11);
        tick(300);
        check("R11 hold", {sts_o, irq_line_o}, 2'b11);
        clr();
        check("R11 cleared", {sts_o, irq_line_o}, 0);
        tick(300);
        cfg_wr(cw(1, 1, 0, 0, 0, 5'd25), 2'b01);
        check("R12 same cfg keeps", sts_o, 1);
        cfg_wr(cw(1, 1, 0, 0, 0, 5'd26), 2'b01);
        check("R12 route change", {sts_o, irq_line_o}, 0);
        tick(300);
        check("R11 set again", sts_o, 1);
        cfg_wr(cw(1, 0, 0, 0, 0, 5'd26), 2'b01);
        check("R12 disable", sts_o, 0);
        cfg_wr(cw(1, 1, 0, 0, 0, 5'd26), 2'b01);
        tick(300);
        check("R11 set third", sts_o, 1);
        cfg_wr(cw(0, 1, 0, 0, 0, 5'd26), 2'b01);
        check("R12 to edge", sts_o, 0);
        cfg_wr(cw(1, 1, 0, 0, 0, 5'd26), 2'b01);
        tick(300);
        cfg_wr(cw(1, 1, 0, 0, 1, 5'd26), 2'b01);
        check("R12 to message", sts_o, 0);

        // R9 message delivery
        msg_wr(64'hFEE0_1000_0000_0041);
        cfg_wr(cw(0, 1, 0, 0, 1, 5'd0), 2'b01);
        tick(300);
        check("R9 request", msg_req_o, 1);
        check("R9 addr", msg_addr_o, 32'hFEE0_1000);
        check("R9 data", msg_data_o, 32'h0000_0041);
        check("R9 no line", irq_line_o, 0);
        @(negedge clk);
        check("R9 one cycle", msg_req_o, 0);

        // R10 edge with route 0
        cfg_wr(cw(0, 1, 0, 0, 0, 5'd0), 2'b01);
        tick(300);
        check("R10 unrouted", {irq_line_o, sts_o, msg_req_o}, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule